// File: doc/BRIEF.md
# Bit-Aligned Receive Packer with Collision Capture

This block sits behind a receive bit decoder. It packs the decoded bits into bytes for a receive FIFO. At the start of each frame a 3-bit alignment value sets where the first received bit lands inside the first byte. An alignment of 0 gives plain byte-oriented reception. Any other value gives a bit-oriented frame, where the first byte holds only its upper positions. Every completed byte comes out as a one-cycle strobe with its data. At end of frame, a partly filled byte is flushed and the count of its occupied bit positions is reported.

While packing, the block also tracks collisions that the decoder flags bit by bit. It keeps the position of the first collision in the frame, counted in bit positions with the alignment offset included. The position is marked valid only when it falls inside the first 64 positions. A control input selects whether bits received after that first collision are kept as received or forced to zero. Forcing them to zero is what a bit-wise anticollision loop expects.

A two-state controller (`ST_IDLE`, `ST_RECV`) gates everything. The transitions are:
- `ST_IDLE` goes to `ST_RECV` on `rx_start`.
- `ST_RECV` restarts itself on `rx_start`.
- `ST_RECV` goes back to `ST_IDLE` on `rx_end`.

Each cycle the controller issues one of three commands to the datapath: clear, take a bit, or close the frame.

Top module: `rx_bit_packer`

## Requirements
- R1: On `rx_start`, the first bit taken is stored at byte position `align`, and each following bit at the next higher position. A byte is output with `byte_vld` high for one cycle, in the cycle after the bit that fills its position 7.
- R2: With `align` = 7, the first bit forms byte 0 alone at position 7 (byte 0 = 0x80 when that bit is 1). The second bit goes to position 0 of the next byte.
- R3: With `align` = 0, received bit i (counting from 0) is stored at position i mod 8 of byte i/8.
- R4: On `rx_end`, a byte that holds at least one position is output, with its unoccupied upper positions at zero. In the same cycle, `last_bits` is set to the number of positions used in that byte: (align + bit count) mod 8, where 0 means the final byte was full. No extra byte is output when the count is 0. A bit taken in the same cycle as `rx_end` belongs to the frame.
- R5: `last_bits` becomes 0 in the cycle after `rx_start`.
- R6: With `keep_after_coll` = 0, every bit taken after the first flagged collision is stored as 0. The colliding bit itself is stored as received.
- R7: With `keep_after_coll` = 1, bits after a collision are stored as received.
- R8: Only the first collision of a frame is recorded. Its position is `align` plus the index of the colliding bit. Later collisions leave `coll_pos` and `coll_pos_vld` unchanged.
- R9: `coll_pos_vld` is set only if the recorded position is below 64. A first collision at position 64 or beyond leaves `coll_pos` = 0 and `coll_pos_vld` = 0.
- R10: `rx_start` clears `coll_pos` and `coll_pos_vld` in the following cycle.
- R11: Bits and `rx_end` are ignored outside a frame. `rx_start` overrides the other inputs in the same cycle, and a new `rx_start` inside a frame discards the partly packed byte.
- R12: After reset, `byte_vld`, `byte_data`, `last_bits`, `coll_pos` and `coll_pos_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Start-of-reception pulse |
| rx_end | input | 1 | End-of-frame pulse |
| bit_vld | input | 1 | A decoded bit is present this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| bit_coll | input | 1 | The decoded bit carries a collision |
| align | input | 3 | Position of the first bit in the first byte, sampled on `rx_start` |
| keep_after_coll | input | 1 | 1: keep bits after a collision; 0: force them to zero |
| byte_vld | output | 1 | One-cycle strobe for a packed byte |
| byte_data | output | 8 | Packed byte |
| last_bits | output | 3 | Positions used in the final byte, 0 when full |
| coll_pos | output | 7 | Position of the first collision, alignment included |
| coll_pos_vld | output | 1 | `coll_pos` holds a position below 64 |

## Verification
The assertions check the following on every cycle:
- the clearing effect of `rx_start` on the count and the collision record;
- that no byte is output from idle;
- that a flushed partial byte has zero upper bits;
- that the first-collision record stays frozen for the rest of the frame.

Only the bench scenarios can show the actual packing. These cover:
- where bits land for several alignments, including the wrap at 7;
- the zero-forcing after a collision;
- the exact collision position values;
- the limit at 64 positions;
- a restart in the middle of a frame.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic clr;
        logic take;
        logic close;
    } rx_ctl_t;

endpackage

// File: rtl/rxpk_fsm.sv
module rxpk_fsm
    import rxpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_start,
    input  logic      rx_end,
    input  logic      bit_vld,
    output rx_state_e state,
    output rx_ctl_t   ctl
);

    rx_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rx_start) state_nx = ST_RECV;
            ST_RECV: begin
                if (rx_start)    state_nx = ST_RECV;
                else if (rx_end) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Commands to the datapath
    always_comb begin
        ctl = '0;
        ctl.clr = rx_start;
        unique case (state)
            ST_IDLE: ;
            ST_RECV: begin
                ctl.take  = !rx_start && bit_vld;
                ctl.close = !rx_start && rx_end;
            end
            default: ;
        endcase
    end

    // R11: a take command is only issued while a frame is active.
    assert_take_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.take |-> (state == ST_RECV));

endmodule

// File: rtl/rxpk_assembler.sv
module rxpk_assembler
    import rxpk_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  rx_ctl_t       ctl,
    input  logic [PW-1:0] align,
    input  logic          bit_val,
    input  logic          keep,
    input  logic          coll_seen,
    output logic          byte_vld,
    output logic [W-1:0]  byte_data,
    output logic [PW-1:0] last_bits
);

    localparam logic [PW-1:0] TOP_POS = PW'(W - 1);

    logic [PW-1:0] ptr_q, ptr_n;
    logic [W-1:0]  acc_q, acc_n;
    logic          bit_eff, full;

    always_comb begin
        bit_eff = bit_val & ~(coll_seen & ~keep);
        acc_n   = ctl.take ? (acc_q | (W'(bit_eff) << ptr_q)) : acc_q;
        ptr_n   = ctl.take ? (ptr_q + PW'(1)) : ptr_q;
        full    = ctl.take && (ptr_q == TOP_POS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            acc_q     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            last_bits <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (ctl.clr) begin
                ptr_q     <= align;
                acc_q     <= '0;
                last_bits <= '0;
            end else begin
                if (ctl.take) begin
                    ptr_q <= ptr_n;
                    acc_q <= full ? '0 : acc_n;
                end
                if (full || (ctl.close && (ptr_n != '0))) begin
                    byte_vld  <= 1'b1;
                    byte_data <= acc_n;
                end
                if (ctl.close) begin
                    last_bits <= ptr_n;
                    acc_q     <= '0;
                    ptr_q     <= '0;
                end
            end
        end
    end

    // R4: a flushed partial byte has nothing above its used positions.
    assert_partial_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && (last_bits != '0)) |-> ((byte_data >> last_bits) == '0));

    // R1: a byte only appears after a bit or a frame close.
    assert_byte_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_vld) |-> $past(ctl.take || ctl.close));

endmodule

// File: rtl/rxpk_coll_track.sv
module rxpk_coll_track
    import rxpk_pkg::*;
#(
    parameter int PW    = 3,
    parameter int LIMIT = 64,
    parameter int POS_W = 7,
    parameter int CW    = $clog2(LIMIT + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  rx_ctl_t          ctl,
    input  logic [PW-1:0]    align,
    input  logic             bit_coll,
    output logic             coll_seen,
    output logic [POS_W-1:0] coll_pos,
    output logic             coll_vld
);

    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            coll_seen <= 1'b0;
            coll_pos  <= '0;
            coll_vld  <= 1'b0;
        end else if (ctl.clr) begin
            cnt_q     <= CW'(align);
            coll_seen <= 1'b0;
            coll_pos  <= '0;
            coll_vld  <= 1'b0;
        end else if (ctl.take) begin
            if (bit_coll && !coll_seen) begin
                coll_seen <= 1'b1;
                if (cnt_q < CNT_MAX) begin
                    coll_pos <= POS_W'(cnt_q);
                    coll_vld <= 1'b1;
                end
            end
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
        end
    end

    // R10: a start clears the collision record.
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr |=> (!coll_vld && (coll_pos == '0) && !coll_seen));

    // R8: once the first collision is seen, the record is frozen.
    assert_first_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_seen && !ctl.clr) |=> ($stable(coll_pos) && $stable(coll_vld)));

    // R9: validity only rises on an accepted colliding bit.
    assert_vld_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_vld) |-> $past(bit_coll && ctl.take));

endmodule

// File: rtl/rx_bit_packer.sv
module rx_bit_packer
    import rxpk_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int COLL_LIMIT = 64,
    parameter int POS_W      = 7,
    parameter int PW         = $clog2(BYTE_W)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_start,
    input  logic             rx_end,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             bit_coll,
    input  logic [PW-1:0]    align,
    input  logic             keep_after_coll,
    output logic             byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic [PW-1:0]    last_bits,
    output logic [POS_W-1:0] coll_pos,
    output logic             coll_pos_vld
);

    rx_state_e state;
    rx_ctl_t   ctl;
    logic      coll_seen;

    rxpk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_start (rx_start),
        .rx_end   (rx_end),
        .bit_vld  (bit_vld),
        .state    (state),
        .ctl      (ctl)
    );

    rxpk_assembler #(.W(BYTE_W), .PW(PW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .align     (align),
        .bit_val   (bit_val),
        .keep      (keep_after_coll),
        .coll_seen (coll_seen),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .last_bits (last_bits)
    );

    rxpk_coll_track #(.PW(PW), .LIMIT(COLL_LIMIT), .POS_W(POS_W)) u_coll (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .align     (align),
        .bit_coll  (bit_coll),
        .coll_seen (coll_seen),
        .coll_pos  (coll_pos),
        .coll_vld  (coll_pos_vld)
    );

    // R5: start resets the last-byte count.
    assert_start_lastbits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> (last_bits == '0));

    // R11: nothing is emitted from idle without a start.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !rx_start) |=> !byte_vld);

endmodule

// File: tb/tb_rx_bit_packer.sv
module tb_rx_bit_packer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 0, rx_end = 0, bit_vld = 0, bit_val = 0, bit_coll = 0;
    logic [2:0] align = 0;
    logic       keep_after_coll = 1;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic [2:0] last_bits;
    logic [6:0] coll_pos;
    logic       coll_pos_vld;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rx_bit_packer dut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_end(rx_end),
        .bit_vld(bit_vld), .bit_val(bit_val), .bit_coll(bit_coll),
        .align(align), .keep_after_coll(keep_after_coll),
        .byte_vld(byte_vld), .byte_data(byte_data), .last_bits(last_bits),
        .coll_pos(coll_pos), .coll_pos_vld(coll_pos_vld)
    );

    // Byte monitor
    logic [7:0] got [0:63];
    int got_n = 0;
    always @(negedge clk) begin
        if (byte_vld) begin
            got[got_n % 64] = byte_data;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  al;
        logic        kp;
        logic [6:0]  n;
        logic [15:0] bits;
        logic [15:0] coll;
        logic [1:0]  nb;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [2:0]  last;
        logic [6:0]  cpos;
        logic        cv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 7'd8,  16'h00A5, 16'h0000, 2'd1, 8'hA5, 8'h00, 3'd0, 7'd0, 1'b0},
        '{3'd0, 1'b1, 7'd12, 16'h0F3C, 16'h0000, 2'd2, 8'h3C, 8'h0F, 3'd4, 7'd0, 1'b0},
        '{3'd4, 1'b1, 7'd4,  16'h000A, 16'h0008, 2'd1, 8'hA0, 8'h00, 3'd0, 7'd7, 1'b1},
        '{3'd7, 1'b1, 7'd3,  16'h0005, 16'h0000, 2'd2, 8'h80, 8'h02, 3'd2, 7'd0, 1'b0},
        '{3'd0, 1'b0, 7'd8,  16'h00FF, 16'h0024, 2'd1, 8'h07, 8'h00, 3'd0, 7'd2, 1'b1},
        '{3'd0, 1'b1, 7'd8,  16'h00FF, 16'h0024, 2'd1, 8'hFF, 8'h00, 3'd0, 7'd2, 1'b1},
        '{3'd3, 1'b1, 7'd5,  16'h001F, 16'h0000, 2'd1, 8'hF8, 8'h00, 3'd0, 7'd0, 1'b0},
        '{3'd5, 1'b0, 7'd6,  16'h003F, 16'h0002, 2'd2, 8'h60, 8'h00, 3'd3, 7'd6, 1'b1}
    };

    task automatic start_frame(input logic [2:0] al, input logic kp);
        @(negedge clk);
        rx_start = 1; align = al; keep_after_coll = kp;
        @(negedge clk);
        rx_start = 0;
    endtask

    task automatic send_bits(input int n, input logic [79:0] bits, input logic [79:0] coll);
        for (int i = 0; i < n; i++) begin
            bit_vld = 1; bit_val = bits[i]; bit_coll = coll[i];
            @(negedge clk);
        end
        bit_vld = 0; bit_val = 0; bit_coll = 0;
    endtask

    task automatic end_frame();
        rx_end = 1;
        @(negedge clk);
        rx_end = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "byte_vld", int'(byte_vld), 0);
        chk("R12", "byte_data", int'(byte_data), 0);
        chk("R12", "last_bits", int'(last_bits), 0);
        chk("R12", "coll_pos", int'(coll_pos), 0);
        chk("R12", "coll_pos_vld", int'(coll_pos_vld), 0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            base = got_n;
            start_frame(VECS[v].al, VECS[v].kp);
            send_bits(int'(VECS[v].n), 80'(VECS[v].bits), 80'(VECS[v].coll));
            end_frame();
            chk("R1/R4", $sformatf("vec%0d byte count", v), got_n - base, int'(VECS[v].nb));
            chk("R1/R2/R3/R6/R7", $sformatf("vec%0d byte0", v), int'(got[base % 64]), int'(VECS[v].b0));
            if (VECS[v].nb > 1)
                chk("R2/R3/R4", $sformatf("vec%0d byte1", v), int'(got[(base + 1) % 64]), int'(VECS[v].b1));
            chk("R4", $sformatf("vec%0d last_bits", v), int'(last_bits), int'(VECS[v].last));
            chk("R8", $sformatf("vec%0d coll_pos", v), int'(coll_pos), int'(VECS[v].cpos));
            chk("R8/R9", $sformatf("vec%0d coll_pos_vld", v), int'(coll_pos_vld), int'(VECS[v].cv));
        end

        // R5 / R10: start clears a nonzero count and a valid collision record
        start_frame(3'd0, 1'b1);
        send_bits(4, 80'hF, 80'h2);
        end_frame();
        chk("R4", "pre last_bits", int'(last_bits), 4);
        chk("R8", "pre coll_pos_vld", int'(coll_pos_vld), 1);
        start_frame(3'd0, 1'b1);
        chk("R5", "last_bits after start", int'(last_bits), 0);
        chk("R10", "coll_pos after start", int'(coll_pos), 0);
        chk("R10", "coll_pos_vld after start", int'(coll_pos_vld), 0);
        end_frame();

        // R11: bits and end outside a frame are ignored
        base = got_n;
        send_bits(16, 80'hFFFF, 80'h0);
        end_frame();
        chk("R11", "idle bytes", got_n - base, 0);

        // R1 timing: strobe one cycle after the completing bit
        start_frame(3'd0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            if (i == 7) chk("R1", "byte_vld before 8th bit", int'(byte_vld), 0);
            bit_vld = 1; bit_val = 1;
            @(negedge clk);
        end
        bit_vld = 0;
        chk("R1", "byte_vld after 8th bit", int'(byte_vld), 1);
        chk("R1", "byte_data after 8th bit", int'(byte_data), 8'hFF);
        end_frame();

        // R9: collision at position 63 is valid
        base = got_n;
        start_frame(3'd0, 1'b1);
        send_bits(64, 80'h0, 80'h1 << 63);
        end_frame();
        chk("R9", "pos63 coll_pos", int'(coll_pos), 63);
        chk("R9", "pos63 coll_pos_vld", int'(coll_pos_vld), 1);
        chk("R3", "64 bits byte count", got_n - base, 8);

        // R9: align 7, collision on bit 57 -> position 64 -> invalid
        base = got_n;
        start_frame(3'd7, 1'b1);
        send_bits(58, 80'h0, 80'h1 << 57);
        end_frame();
        chk("R9", "pos64 coll_pos_vld", int'(coll_pos_vld), 0);
        chk("R9", "pos64 coll_pos", int'(coll_pos), 0);
        chk("R4", "align7 58 bits last_bits", int'(last_bits), 1);
        chk("R2", "align7 58 bits byte count", got_n - base, 9);

        // R11: restart inside a frame discards the partial byte
        base = got_n;
        start_frame(3'd2, 1'b1);
        send_bits(5, 80'h1F, 80'h0);
        start_frame(3'd0, 1'b1);
        send_bits(8, 80'h5A, 80'h0);
        end_frame();
        chk("R11", "restart byte count", got_n - base, 1);
        chk("R11", "restart byte", int'(got[base % 64]), 8'h5A);

        // R4: bit in the same cycle as end belongs to the frame
        base = got_n;
        start_frame(3'd0, 1'b1);
        send_bits(2, 80'h3, 80'h0);
        bit_vld = 1; bit_val = 1; rx_end = 1;
        @(negedge clk);
        bit_vld = 0; bit_val = 0; rx_end = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "end+bit byte", int'(got[base % 64]), 8'h07);
        chk("R4", "end+bit last_bits", int'(last_bits), 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule